// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a 32-bit core whose visible registers depend on the execution mode. It has two combinational read ports and one clocked write port, each addressed by a 4-bit register number from 0 to 15, plus a 5-bit mode input. Every access is steered to the physical copy owned by the current mode. Number 15, the program counter, is an ordinary shared slot.

The fast-interrupt mode owns private copies of registers 8 through 14. The IRQ, supervisor, abort and undefined modes each own a private stack pointer (13) and link register (14). They also own a saved status word, which is read and written through a dedicated port pair that follows the current mode. A parameter adds the monitor mode, with its own 13, 14 and saved status word. User and system modes share the base bank and have no saved status word.

With the security parameter off, the store holds 31 general copies and 5 saved status words. With it on, it holds 33 and 6.

Top module: `bank_regfile`

## Requirements
- R1: An active-low reset clears every physical register and every saved status word to zero.
- R2: Registers 0 to 7 and register 15 are a single shared copy in every mode.
- R3: In FIQ mode, registers 8 to 14 reach private copies. Other modes never see these copies.
- R4: The IRQ, supervisor, abort and undefined modes each have private registers 13 and 14. Their registers 8 to 12 are the base-bank copies.
- R5: With SEC_EXT=1, monitor mode has private registers 13 and 14 and its own saved status word. With SEC_EXT=0, the monitor code uses the base bank, its saved status read returns zero, and its saved status write is ignored.
- R6: Each exception mode (FIQ, IRQ, supervisor, abort, undefined, and monitor when enabled) has one saved status word. The saved status port reads and writes the word of the current mode.
- R7: User and system modes share one bank. In these modes, a saved status read returns zero and a saved status write changes no saved status word.
- R8: Reads are combinational. A write lands on the rising clock edge, in the bank chosen by the mode value present in that cycle.
- R9: A read of the physical register being written in the same cycle returns its old value. There is no bypass.
- R10: The mode codes are 0x10 user, 0x11 FIQ, 0x12 IRQ, 0x13 supervisor, 0x16 monitor, 0x17 abort, 0x1B undefined and 0x1F system. Any other code behaves as user.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Current execution mode code |
| rd_a_idx | input | 4 | Register number for read port A |
| rd_a_data | output | DATA_W | Read port A data |
| rd_b_idx | input | 4 | Register number for read port B |
| rd_b_data | output | DATA_W | Read port B data |
| wr_en | input | 1 | Write enable for the general registers |
| wr_idx | input | 4 | Register number to write |
| wr_data | input | DATA_W | Write data |
| sps_rd_data | output | DATA_W | Saved status word of the current mode |
| sps_wr_en | input | 1 | Write enable for the saved status word |
| sps_wr_data | input | DATA_W | Saved status write data |

## Verification
The bench drives two copies of the block, one with the monitor bank and one without. It targets bank leakage:
- A FIQ write that reached the user copy of register 8 would appear on a later user-mode read.
- A stack pointer shared between IRQ and supervisor would show the wrong value after each mode wrote its own.
- A banked program counter would lose a value written in FIQ and read back in IRQ.

It reads the saved status port in user and system modes, and in monitor mode on the copy without the monitor bank. A design that decoded those modes into a real word would return nonzero data there, or would corrupt a neighbouring mode's word. Writes overlap reads of the same register, so a forwarding path shows up as new data one cycle early. A mid-run reset is followed by reads of banks that held data, to catch any copy that escapes the clear.

// File: rtl/bank_regfile_pkg.sv
package bank_regfile_pkg;

  localparam logic [4:0] MODE_USR = 5'h10;
  localparam logic [4:0] MODE_FIQ = 5'h11;
  localparam logic [4:0] MODE_IRQ = 5'h12;
  localparam logic [4:0] MODE_SVC = 5'h13;
  localparam logic [4:0] MODE_MON = 5'h16;
  localparam logic [4:0] MODE_ABT = 5'h17;
  localparam logic [4:0] MODE_UND = 5'h1B;
  localparam logic [4:0] MODE_SYS = 5'h1F;

  typedef enum logic [2:0] {
    BK_BASE = 3'd0,
    BK_FIQ  = 3'd1,
    BK_IRQ  = 3'd2,
    BK_SVC  = 3'd3,
    BK_ABT  = 3'd4,
    BK_UND  = 3'd5,
    BK_MON  = 3'd6
  } bank_e;

  localparam int unsigned NUM_ARCH   = 16;
  localparam int unsigned FIQ_BASE   = 16;
  localparam int unsigned FIQ_COUNT  = 7;
  localparam int unsigned PAIR_BASE  = FIQ_BASE + FIQ_COUNT;

  function automatic bank_e mode_bank(input logic [4:0] mode, input bit sec);
    case (mode)
      MODE_FIQ: return BK_FIQ;
      MODE_IRQ: return BK_IRQ;
      MODE_SVC: return BK_SVC;
      MODE_ABT: return BK_ABT;
      MODE_UND: return BK_UND;
      MODE_MON: return sec ? BK_MON : BK_BASE;
      default:  return BK_BASE;
    endcase
  endfunction

endpackage

// File: rtl/bank_map.sv
module bank_map
  import bank_regfile_pkg::*;
#(
  parameter bit          SEC_EXT = 1'b0,
  parameter int unsigned PHYS_W  = 6
) (
  input  logic [4:0]        mode_i,
  input  logic [3:0]        idx_i,
  output logic [PHYS_W-1:0] phys_o
);

  bank_e bank;
  logic  fiq_hit;
  logic  pair_hit;

  always_comb begin
    bank     = mode_bank(mode_i, SEC_EXT);
    fiq_hit  = (bank == BK_FIQ) && (idx_i >= 4'd8) && (idx_i <= 4'd14);
    pair_hit = (bank >= BK_IRQ) && ((idx_i == 4'd13) || (idx_i == 4'd14));
    if (fiq_hit) begin
      phys_o = PHYS_W'(FIQ_BASE) + PHYS_W'(idx_i - 4'd8);
    end else if (pair_hit) begin
      phys_o = PHYS_W'(PAIR_BASE) + PHYS_W'({bank - BK_IRQ, 1'b0})
             + PHYS_W'(idx_i - 4'd13);
    end else begin
      phys_o = PHYS_W'(idx_i);
    end
  end

endmodule

// File: rtl/sps_map.sv
module sps_map
  import bank_regfile_pkg::*;
#(
  parameter bit          SEC_EXT = 1'b0,
  parameter int unsigned SEL_W   = 3
) (
  input  logic [4:0]       mode_i,
  output logic             hit_o,
  output logic [SEL_W-1:0] sel_o
);

  bank_e bank;

  always_comb begin
    bank  = mode_bank(mode_i, SEC_EXT);
    hit_o = (bank != BK_BASE);
    sel_o = hit_o ? SEL_W'(bank - BK_FIQ) : '0;
  end

endmodule

// File: rtl/word_store.sv
module word_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 31,
  parameter int unsigned NRD    = 2,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NRD-1:0][AW-1:0]    rd_sel_i,
  output logic [NRD-1:0][DATA_W-1:0] rd_data_o,
  input  logic                      wr_en_i,
  input  logic [AW-1:0]             wr_sel_i,
  input  logic [DATA_W-1:0]         wr_data_i
);

  logic [DATA_W-1:0] mem_q   [DEPTH];
  logic [DATA_W-1:0] mem_nxt [DEPTH];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_nxt[i] = mem_q[i];
    end
    if (wr_en_i && (int'(wr_sel_i) < DEPTH)) begin
      mem_nxt[wr_sel_i] = wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= '0;
      end
    end else if (wr_en_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= mem_nxt[i];
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data_o[p] = (int'(rd_sel_i[p]) < DEPTH) ? mem_q[rd_sel_i[p]] : '0;
  end

endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
  import bank_regfile_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter bit          SEC_EXT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode_i,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] sps_rd_data,
  input  logic              sps_wr_en,
  input  logic [DATA_W-1:0] sps_wr_data
);

  localparam int unsigned NPHYS  = PAIR_BASE + 8 + (SEC_EXT ? 2 : 0);
  localparam int unsigned NSPS   = 5 + (SEC_EXT ? 1 : 0);
  localparam int unsigned PHYS_W = $clog2(NPHYS);
  localparam int unsigned SEL_W  = $clog2(NSPS);
  localparam int unsigned NPORT  = 3;

  logic [NPORT-1:0][3:0]        port_idx;
  logic [NPORT-1:0][PHYS_W-1:0] port_phys;
  logic [1:0][PHYS_W-1:0]       rd_sel;
  logic [1:0][DATA_W-1:0]       rd_word;

  assign port_idx[0] = rd_a_idx;
  assign port_idx[1] = rd_b_idx;
  assign port_idx[2] = wr_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    bank_map #(.SEC_EXT(SEC_EXT), .PHYS_W(PHYS_W)) u_map (
      .mode_i (mode_i),
      .idx_i  (port_idx[p]),
      .phys_o (port_phys[p])
    );
  end

  assign rd_sel[0] = port_phys[0];
  assign rd_sel[1] = port_phys[1];

  word_store #(.DATA_W(DATA_W), .DEPTH(NPHYS), .NRD(2)) u_gpr (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_sel_i  (rd_sel),
    .rd_data_o (rd_word),
    .wr_en_i   (wr_en),
    .wr_sel_i  (port_phys[2]),
    .wr_data_i (wr_data)
  );

  assign rd_a_data = rd_word[0];
  assign rd_b_data = rd_word[1];

  logic                  sps_hit;
  logic [SEL_W-1:0]      sps_sel;
  logic [0:0][SEL_W-1:0] sps_rd_sel;
  logic [0:0][DATA_W-1:0] sps_word;

  sps_map #(.SEC_EXT(SEC_EXT), .SEL_W(SEL_W)) u_sps_map (
    .mode_i (mode_i),
    .hit_o  (sps_hit),
    .sel_o  (sps_sel)
  );

  assign sps_rd_sel[0] = sps_sel;

  word_store #(.DATA_W(DATA_W), .DEPTH(NSPS), .NRD(1)) u_sps (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_sel_i  (sps_rd_sel),
    .rd_data_o (sps_word),
    .wr_en_i   (sps_wr_en && sps_hit),
    .wr_sel_i  (sps_sel),
    .wr_data_i (sps_wr_data)
  );

  assign sps_rd_data = sps_hit ? sps_word[0] : '0;

endmodule

// File: rtl/bank_regfile_chk.sv
module bank_regfile_chk
  import bank_regfile_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        mode_i,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] sps_rd_data,
  input logic              sps_wr_en,
  input logic [DATA_W-1:0] sps_wr_data
);

  logic exc_mode;
  assign exc_mode = (mode_i == MODE_FIQ) || (mode_i == MODE_IRQ) || (mode_i == MODE_SVC)
                 || (mode_i == MODE_ABT) || (mode_i == MODE_UND);

  // R8
  write_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && (mode_i == $past(mode_i)) && (rd_a_idx == $past(wr_idx)))
      |-> (rd_a_data == $past(wr_data)));

  // R2
  shared_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && (($past(wr_idx) < 4'd8) || ($past(wr_idx) == 4'd15))
      && (rd_a_idx == $past(wr_idx)))
      |-> (rd_a_data == $past(wr_data)));

  // R9
  hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_en) && $stable(mode_i) && $stable(rd_a_idx))
      |-> $stable(rd_a_data));

  // R7
  base_sps_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_i == MODE_USR) || (mode_i == MODE_SYS)) |-> (sps_rd_data == '0));

  // R6
  sps_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sps_wr_en) && exc_mode && (mode_i == $past(mode_i)))
      |-> (sps_rd_data == $past(sps_wr_data)));

endmodule

bind bank_regfile bank_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .rd_a_idx    (rd_a_idx),
  .rd_a_data   (rd_a_data),
  .wr_en       (wr_en),
  .wr_idx      (wr_idx),
  .wr_data     (wr_data),
  .sps_rd_data (sps_rd_data),
  .sps_wr_en   (sps_wr_en),
  .sps_wr_data (sps_wr_data)
);

// File: tb/bank_regfile_bench.sv
module bank_regfile_bench;

  localparam logic [4:0] M_USR = 5'h10, M_FIQ = 5'h11, M_IRQ = 5'h12, M_SVC = 5'h13;
  localparam logic [4:0] M_MON = 5'h16, M_ABT = 5'h17, M_UND = 5'h1B, M_SYS = 5'h1F;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [4:0]  mode;
  logic [3:0]  ra, rb, wi;
  logic        we, swe;
  logic [31:0] wd, swd;
  logic [31:0] a_v [2];
  logic [31:0] b_v [2];
  logic [31:0] s_v [2];

  bank_regfile #(.DATA_W(32), .SEC_EXT(1'b0)) u_bank_regfile_nosec (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .rd_a_idx(ra), .rd_a_data(a_v[0]),
    .rd_b_idx(rb), .rd_b_data(b_v[0]), .wr_en(we), .wr_idx(wi), .wr_data(wd),
    .sps_rd_data(s_v[0]), .sps_wr_en(swe), .sps_wr_data(swd));

  bank_regfile #(.DATA_W(32), .SEC_EXT(1'b1)) u_bank_regfile (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .rd_a_idx(ra), .rd_a_data(a_v[1]),
    .rd_b_idx(rb), .rd_b_data(b_v[1]), .wr_en(we), .wr_idx(wi), .wr_data(wd),
    .sps_rd_data(s_v[1]), .sps_wr_en(swe), .sps_wr_data(swd));

  typedef struct {
    string       tag;
    logic [31:0] ea [2];
    logic [31:0] eb [2];
    logic [31:0] es [2];
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [31:0] gm [2][7][16];
  logic [31:0] sm [2][6];

  function automatic int bank_of(input int v, input logic [4:0] m);
    case (m)
      M_FIQ: return 1;
      M_IRQ: return 2;
      M_SVC: return 3;
      M_ABT: return 4;
      M_UND: return 5;
      M_MON: return (v == 1) ? 6 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int owner(input int v, input logic [4:0] m, input logic [3:0] i);
    int c;
    c = bank_of(v, m);
    if (c == 1 && i >= 8 && i <= 14) return 1;
    if (c >= 2 && (i == 13 || i == 14)) return c;
    return 0;
  endfunction

  task automatic clear_model();
    for (int v = 0; v < 2; v++) begin
      for (int c = 0; c < 7; c++) for (int i = 0; i < 16; i++) gm[v][c][i] = '0;
      for (int s = 0; s < 6; s++) sm[v][s] = '0;
    end
  endtask

  task automatic step(input logic [4:0] m, input logic [3:0] a, input logic [3:0] b,
                      input logic w, input logic [3:0] widx, input logic [31:0] wdat,
                      input logic sw, input logic [31:0] swdat, input string tag);
    exp_t e;
    int c;
    @(negedge clk);
    mode = m; ra = a; rb = b; we = w; wi = widx; wd = wdat; swe = sw; swd = swdat;
    e.tag = tag;
    for (int v = 0; v < 2; v++) begin
      c = bank_of(v, m);
      e.ea[v] = gm[v][owner(v, m, a)][a];
      e.eb[v] = gm[v][owner(v, m, b)][b];
      e.es[v] = (c >= 1) ? sm[v][c-1] : '0;
    end
    q.push_back(e);
    for (int v = 0; v < 2; v++) begin
      c = bank_of(v, m);
      if (w) gm[v][owner(v, m, widx)][widx] = wdat;
      if (sw && c >= 1) sm[v][c-1] = swdat;
    end
  endtask

  task automatic rd(input logic [4:0] m, input logic [3:0] a, input logic [3:0] b,
                    input string tag);
    step(m, a, b, 1'b0, 4'd0, 32'd0, 1'b0, 32'd0, tag);
  endtask

  task automatic cmp(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #5;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.tag, "nosec port A", a_v[0], e.ea[0]);
      cmp(e.tag, "nosec port B", b_v[0], e.eb[0]);
      cmp(e.tag, "nosec saved status", s_v[0], e.es[0]);
      cmp(e.tag, "sec port A", a_v[1], e.ea[1]);
      cmp(e.tag, "sec port B", b_v[1], e.eb[1]);
      cmp(e.tag, "sec saved status", s_v[1], e.es[1]);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  logic [4:0] pmodes [4] = '{M_IRQ, M_SVC, M_ABT, M_UND};
  logic [4:0] amodes [9] = '{M_USR, M_FIQ, M_IRQ, M_SVC, M_MON, M_ABT, M_UND, M_SYS, 5'h00};

  initial begin
    rst_n = 1'b0; mode = M_USR; ra = 0; rb = 0; we = 0; wi = 0; wd = 0; swe = 0; swd = 0;
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: everything reads zero after reset
    foreach (amodes[k]) for (int i = 0; i < 16; i++) rd(amodes[k], 4'(i), 4'(15 - i), "R1 reset");

    // R8: user fill; R9: reading the register being written returns the old value
    for (int i = 0; i < 16; i++)
      step(M_USR, 4'(i), 4'(i), 1'b1, 4'(i), 32'h1000_0000 + i, 1'b0, 0, "R9 fill old value");
    for (int i = 0; i < 16; i++) rd(M_USR, 4'(i), 4'(15 - i), "R8 user readback");

    // R3: FIQ private 8..14
    for (int i = 8; i < 15; i++)
      step(M_FIQ, 4'(i), 4'(i - 8), 1'b1, 4'(i), 32'hF100_0000 + i, 1'b0, 0, "R3 fiq write");
    for (int i = 0; i < 16; i++) rd(M_FIQ, 4'(i), 4'(i), "R3 fiq readback");
    for (int i = 8; i < 15; i++) rd(M_USR, 4'(i), 4'(i), "R3 user untouched");

    // R4: private 13/14 per mode, shared 8..12
    foreach (pmodes[k]) begin
      step(pmodes[k], 4'd12, 4'd13, 1'b1, 4'd13, 32'hA000_0000 + k, 1'b0, 0, "R4 sp write");
      step(pmodes[k], 4'd8, 4'd14, 1'b1, 4'd14, 32'hB000_0000 + k, 1'b0, 0, "R4 lr write");
    end
    foreach (amodes[k]) for (int i = 8; i < 16; i++) rd(amodes[k], 4'(i), 4'(23 - i), "R4 cross read");

    // R2: shared low registers and program counter written in FIQ
    step(M_FIQ, 4'd3, 4'd15, 1'b1, 4'd15, 32'hC0DE_0015, 1'b0, 0, "R2 pc write");
    step(M_FIQ, 4'd3, 4'd15, 1'b1, 4'd3, 32'hC0DE_0003, 1'b0, 0, "R2 r3 write");
    foreach (amodes[k]) rd(amodes[k], 4'd3, 4'd15, "R2 shared read");

    // R6: saved status per exception mode
    step(M_FIQ, 0, 0, 1'b0, 0, 0, 1'b1, 32'h5000_0011, "R6 fiq sps");
    foreach (pmodes[k]) step(pmodes[k], 0, 0, 1'b0, 0, 0, 1'b1, 32'h5000_0100 + k, "R6 sps write");
    foreach (amodes[k]) rd(amodes[k], 0, 1, "R6 sps readback");

    // R7: user/system share; saved status zero and write ignored
    step(M_USR, 0, 0, 1'b0, 0, 0, 1'b1, 32'hDEAD_BEEF, "R7 user sps write");
    step(M_SYS, 4'd13, 4'd14, 1'b1, 4'd13, 32'h5A5A_0013, 1'b1, 32'hFEED_FACE, "R7 sys write");
    rd(M_USR, 4'd13, 4'd14, "R7 user sees sys write");
    foreach (amodes[k]) rd(amodes[k], 4'd13, 4'd0, "R7 sps unchanged");

    // R5: monitor bank present only with the security parameter
    step(M_MON, 4'd13, 4'd14, 1'b1, 4'd13, 32'h3333_0013, 1'b1, 32'h3333_5555, "R5 mon sp");
    step(M_MON, 4'd13, 4'd14, 1'b1, 4'd14, 32'h3333_0014, 1'b0, 0, "R5 mon lr");
    rd(M_MON, 4'd13, 4'd14, "R5 mon readback");
    rd(M_USR, 4'd13, 4'd14, "R5 base view");
    rd(M_SVC, 4'd13, 4'd14, "R5 svc view");

    // R10: unknown mode code behaves as user
    step(5'h00, 4'd14, 4'd9, 1'b1, 4'd14, 32'h0BAD_0014, 1'b1, 32'h0BAD_5555, "R10 odd mode write");
    rd(M_USR, 4'd14, 4'd9, "R10 user view");
    rd(M_FIQ, 4'd14, 4'd9, "R10 fiq view");

    // R8: write lands in the bank of the cycle's mode, then mode changes
    step(M_ABT, 4'd13, 4'd13, 1'b1, 4'd13, 32'h7777_0013, 1'b0, 0, "R8 abt write");
    rd(M_UND, 4'd13, 4'd13, "R8 und after abt write");
    rd(M_ABT, 4'd13, 4'd13, "R8 abt readback");

    // R1: reset mid-run clears every bank
    @(negedge clk);
    rst_n = 1'b0; we = 0; swe = 0;
    clear_model();
    @(negedge clk);
    rst_n = 1'b1;
    foreach (amodes[k]) for (int i = 0; i < 16; i++) rd(amodes[k], 4'(i), 4'(15 - i), "R1 mid reset");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule